// File: doc/BRIEF.md
# Complementary PWM Channel with Dead-Time Insertion

This block is one edge-aligned PWM channel. It drives a high-side and a low-side gate signal for a half-bridge. A free-running up-counter spans a programmable number of clock cycles per period. A duty compare sets how much of each period the ideal waveform is high. The high-side gate follows that waveform and the low-side gate follows its complement.

Dead-time insertion can be switched on with its own enable. Each side then has its own 16-bit delay count. A gate turns on only after its own delay has passed since the opposite gate released, so the two gates are never on together. Pulses or gaps that are too short for the dead time are dropped, which avoids slivers on the outputs.

Period and duty are shadowed and are taken only at the period boundary. A one-cycle strobe marks the start of each period. For example, a period of 5600 at an 84 MHz clock gives a 15 kHz rate, and a dead time of 168 cycles gives 2 µs.

Top module: `cpwm_channel`

## Requirements
- R1: `period_start_o` is high for exactly one cycle at the start of each period. Strobes are P cycles apart, where P is the latched period value; a value of 0 acts as 1.
- R2: With dead time off, `gate_hi_o` rises one cycle after the strobe and stays high for min(D, P) cycles of each period, where D is the latched duty. D = 0 keeps it low.
- R3: With dead time on, the rise of `gate_hi_o` is delayed by `dt_hi_i` extra cycles compared with R2, and its fall is not moved.
- R4: With dead time on, `gate_lo_o` rises `dt_lo_i` cycles after the cycle in which `gate_hi_o` would fall under R2. It falls in the cycle where `gate_hi_o` would rise under R2.
- R5: `gate_hi_o` and `gate_lo_o` are never high in the same cycle.
- R6: If a high pulse lasts no more than `dt_hi_i` cycles, `gate_hi_o` stays low for it. If a gap lasts no more than `dt_lo_i` cycles, `gate_lo_o` stays low for it.
- R7: New `period_i` and `duty_i` values take effect only at the period boundary. While `en_i` is low they are taken every cycle.
- R8: From the second clock edge after `en_i` is seen low, both gates are low. When `en_i` returns, the counter restarts from zero and a strobe follows one cycle later.
- R9: While `rst_n` is low, all three outputs are low.
- R10: A period of 65535 counts is supported, so strobes are 65535 cycles apart.
- R11: With dead time off and the channel running, `gate_lo_o` is the exact complement of `gate_hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel run enable |
| period_i | input | 16 | Period length in clock cycles |
| duty_i | input | 16 | Cycles per period that the ideal waveform is high |
| dt_en_i | input | 1 | Dead-time insertion enable |
| dt_hi_i | input | 16 | Delay before the high-side gate turns on |
| dt_lo_i | input | 16 | Delay before the low-side gate turns on |
| gate_hi_o | output | 1 | High-side gate drive |
| gate_lo_o | output | 1 | Low-side gate drive |
| period_start_o | output | 1 | One-cycle strobe at each period start |

## Verification
The hardest case to reach is a pulse or gap whose length is equal to or shorter than its dead-time count, because the gate must then stay silent instead of emitting a clipped sliver. The stimulus reaches it with a short 10-cycle period and duty values of 2 and 9 against dead times of 2 and 1, so both the high-side pulse and the low-side gap sit exactly on the limit. Duty and period are also changed in the middle of a period, so a late latch shows up as a wrong pulse length. A scoreboard model built from the requirements predicts every output cycle. Long 5600- and 65535-count periods check strobe spacing and the width of the clipped high-side pulse.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned CPWM_CNT_W = 16;
  localparam int unsigned CPWM_DT_W  = 16;
  localparam int unsigned CPWM_SIDES = 2;
  localparam int unsigned CPWM_HI    = 0;
  localparam int unsigned CPWM_LO    = 1;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int unsigned CNT_W = cpwm_pkg::CPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             ideal_o,
  output logic             start_o,
  output logic             run_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             ideal_q, ideal_d;
  logic             start_q, start_d;
  logic             run_q;
  logic [EXT_W-1:0] cnt_inc;
  logic             last;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
  assign last    = (cnt_inc >= {1'b0, per_q});

  always_comb begin
    cnt_d  = cnt_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (!en_i) begin
      cnt_d  = '0;
      per_d  = period_i;
      duty_d = duty_i;
    end else if (last) begin
      cnt_d  = '0;
      per_d  = period_i;
      duty_d = duty_i;
    end else begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
    ideal_d = en_i && (cnt_q < duty_q);
    start_d = en_i && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      ideal_q <= 1'b0;
      start_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      duty_q  <= duty_d;
      ideal_q <= ideal_d;
      start_q <= start_d;
      run_q   <= en_i;
    end
  end

  assign ideal_o = ideal_q;
  assign start_o = start_q;
  assign run_o   = run_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0) ? (cnt_q == '0) : (cnt_q < per_q));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !last) |=> ($stable(per_q) && $stable(duty_q)));
endmodule

// File: rtl/cpwm_dt_side.sv
module cpwm_dt_side #(
  parameter int unsigned DT_W = cpwm_pkg::CPWM_DT_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            act_i,
  input  logic            dly_en_i,
  input  logic [DT_W-1:0] dly_i,
  output logic            gate_o
);
  localparam logic [DT_W-1:0] RUN_MAX = '1;

  logic [DT_W-1:0] run_q, run_d;
  logic            gate_q, gate_d;

  always_comb begin
    if (!act_i)
      run_d = '0;
    else if (run_q != RUN_MAX)
      run_d = run_q + DT_W'(1);
    else
      run_d = run_q;
    gate_d = act_i && (!dly_en_i || (run_q >= dly_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

  // R6
  gate_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> $past(act_i));

  // R3
  rise_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o) && $past(dly_en_i) && ($past(dly_i) != '0)) |-> $past(act_i, 2));
endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel #(
  parameter int unsigned CNT_W = cpwm_pkg::CPWM_CNT_W,
  parameter int unsigned DT_W  = cpwm_pkg::CPWM_DT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             dt_en_i,
  input  logic [DT_W-1:0]  dt_hi_i,
  input  logic [DT_W-1:0]  dt_lo_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o,
  output logic             period_start_o
);
  import cpwm_pkg::*;

  logic                         ideal;
  logic                         run;
  logic [CPWM_SIDES-1:0]        side_act;
  logic [CPWM_SIDES-1:0]        side_gate;
  logic [CPWM_SIDES-1:0][DT_W-1:0] side_dly;

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .ideal_o  (ideal),
    .start_o  (period_start_o),
    .run_o    (run)
  );

  assign side_act[CPWM_HI] = ideal;
  assign side_act[CPWM_LO] = run && !ideal;
  assign side_dly[CPWM_HI] = dt_hi_i;
  assign side_dly[CPWM_LO] = dt_lo_i;

  for (genvar g = 0; g < CPWM_SIDES; g++) begin : g_side
    cpwm_dt_side #(.DT_W(DT_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_i    (side_act[g]),
      .dly_en_i (dt_en_i),
      .dly_i    (side_dly[g]),
      .gate_o   (side_gate[g])
    );
  end

  assign gate_hi_o = side_gate[CPWM_HI];
  assign gate_lo_o = side_gate[CPWM_LO];

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi_o && gate_lo_o));

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i, 2) |-> (!gate_hi_o && !gate_lo_o));

  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (!gate_hi_o && !gate_lo_o && !period_start_o));
endmodule

// File: tb/cpwm_channel_tb_top.sv
module cpwm_channel_tb_top;
  typedef struct packed { logic hi; logic lo; logic ps; } exp_t;

  localparam int HMAX = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period = 16'd10;
  logic [15:0] duty = 16'd4;
  logic        dt_en = 1'b0;
  logic [15:0] dt_hi = 16'd0;
  logic [15:0] dt_lo = 16'd0;
  logic        gate_hi, gate_lo, pstart;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R9";
  exp_t  sb_q[$];

  int m_cnt, m_per, m_duty;
  bit hi_hist [HMAX];
  bit lo_hist [HMAX];

  always #2.5 clk = ~clk;

  cpwm_channel dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .period_i(period), .duty_i(duty),
    .dt_en_i(dt_en), .dt_hi_i(dt_hi), .dt_lo_i(dt_lo),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .period_start_o(pstart)
  );

  function automatic bit window_all(bit h[HMAX], int d);
    for (int k = 0; k <= d; k++) if (!h[k]) return 1'b0;
    return 1'b1;
  endfunction

  // driver side of the scoreboard: requirement model, one item per edge
  always @(posedge clk) begin
    exp_t e;
    bit   nid, nlo;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0;
      for (int k = 0; k < HMAX; k++) begin hi_hist[k] = 0; lo_hist[k] = 0; end
      e = '0;
    end else begin
      e.hi = dt_en ? window_all(hi_hist, int'(dt_hi)) : hi_hist[0];
      e.lo = dt_en ? window_all(lo_hist, int'(dt_lo)) : lo_hist[0];
      e.ps = en && (m_cnt == 0);
      nid  = en && (m_cnt < m_duty);
      nlo  = en && !nid;
      for (int k = HMAX-1; k > 0; k--) begin hi_hist[k] = hi_hist[k-1]; lo_hist[k] = lo_hist[k-1]; end
      hi_hist[0] = nid;
      lo_hist[0] = nlo;
      if (!en || (m_cnt + 1 >= m_per)) begin
        m_cnt = 0; m_per = int'(period); m_duty = int'(duty);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    sb_q.push_back(e);
  end

  // monitor side of the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      n_chk++;
      if (gate_hi !== e.hi || gate_lo !== e.lo || pstart !== e.ps) begin
        n_fail++;
        $display("FAIL %s: hi/lo/ps actual=%b%b%b expected=%b%b%b at %0t",
                 cur_req, gate_hi, gate_lo, pstart, e.hi, e.lo, e.ps, $time);
      end
      n_chk++;
      if (gate_hi && gate_lo) begin
        n_fail++;
        $display("FAIL R5: both gates high actual=11 expected=not 11 at %0t", $time);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!pstart);
  endtask

  task automatic check_val(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  initial begin
    int span, hicnt;
    cyc(3);
    // R9 reset state
    check_val("R9", "outputs in reset", {gate_hi, gate_lo, pstart}, 0);
    rst_n = 1'b1;
    cyc(2);

    cur_req = "R11"; en = 1'b1; cyc(40);
    cur_req = "R2";  duty = 16'd7; cyc(30);
    cur_req = "R3";  dt_en = 1'b1; dt_hi = 16'd2; dt_lo = 16'd0; cyc(30);
    cur_req = "R4";  dt_lo = 16'd3; cyc(30);
    cur_req = "R6";  duty = 16'd2; cyc(30);
    duty = 16'd9; dt_lo = 16'd1; cyc(30);
    cur_req = "R7";  cyc(3); period = 16'd7; duty = 16'd3; cyc(4); duty = 16'd5; cyc(30);
    cur_req = "R2";  dt_en = 1'b0; duty = 16'd0; cyc(20);
    duty = 16'd20; cyc(20);
    period = 16'd0; cyc(10); period = 16'd1; cyc(10);
    period = 16'd6; duty = 16'd2; cyc(20);
    cur_req = "R8";  en = 1'b0; cyc(1); period = 16'd9; cyc(6); en = 1'b1; cyc(25);
    en = 1'b0; cyc(2); en = 1'b1; cyc(20);

    // R1: 5600-cycle period with a 168-cycle high-side dead time
    cur_req = "R1"; dt_en = 1'b1; dt_hi = 16'd168; dt_lo = 16'd168;
    period = 16'd5600; duty = 16'd2800;
    wait_strobe();
    span = 0; hicnt = 0;
    do begin @(negedge clk); span++; if (gate_hi) hicnt++; end while (!pstart);
    check_val("R1", "strobe spacing", span, 5600);
    check_val("R3", "clipped high-side width", hicnt, 2800 - 168);

    // R10: full 16-bit period
    cur_req = "R10"; period = 16'd65535; duty = 16'd30000;
    wait_strobe();
    span = 0;
    do begin @(negedge clk); span++; end while (!pstart);
    check_val("R10", "strobe spacing", span, 65535);
    cyc(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL %s: watchdog actual=hung expected=done", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule